// File: doc/BRIEF.md
# Selectable Arithmetic Logic Unit

A combinational ALU of parameterised width (4 bits by default). It takes two operands, a carry input and a 3-bit operation select, and returns a result with carry-out and signed overflow. The top select bit chooses between the arithmetic and the logic side. The two lower select bits are shared by both sides.

All arithmetic comes from one ripple adder. The first operand enters the adder unchanged. The second adder input is steered to zero, the second operand, its complement, or all ones. With the carry input, this gives eight arithmetic functions, including increment, add, two's complement subtraction and decrement. The logic side gives AND, OR, XOR and NOT of the first operand.

The datapath is one 1-bit stage, replicated across the width with the carry rippling upward.

Top module: `sel_alu`

## Requirements
- R1: With sel[2]=0, {carry_out, result} equals opa + Y + carry_in, taken modulo 2^(WIDTH+1). Y is chosen by sel[1:0]: 00 gives all zeros, 01 gives opb, 10 gives ~opb, 11 gives all ones.
- R2: sel=000 returns opa when carry_in=0 and opa+1 when carry_in=1.
- R3: sel=001 returns opa+opb when carry_in=0 and opa+opb+1 when carry_in=1.
- R4: sel=010 returns opa-opb (two's complement) when carry_in=1 and opa+~opb when carry_in=0.
- R5: sel=011 returns opa-1 when carry_in=0 and opa when carry_in=1.
- R6: On the arithmetic side, overflow is 1 exactly when the signed sum of opa, Y and carry_in does not fit in WIDTH bits. Carry_out is the adder carry from the top bit.
- R7: With sel[2]=1, sel[1:0] picks the logic function: 00 gives opa AND opb, 01 gives opa OR opb, 10 gives opa XOR opb, 11 gives NOT opa.
- R8: With sel[2]=1, carry_out and overflow are 0, and carry_in has no effect on result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | WIDTH | First operand, fed to the adder unchanged |
| opb | input | WIDTH | Second operand |
| carry_in | input | 1 | Adder carry input |
| sel | input | 3 | Operation select; bit 2 picks logic (1) or arithmetic (0) |
| result | output | WIDTH | Selected result |
| carry_out | output | 1 | Adder carry out; 0 in logic mode |
| overflow | output | 1 | Signed overflow; 0 in logic mode |

## Verification
The bench targets the wrap points of the adder. These are decrement of zero, increment of all ones, subtraction that borrows, and additions that cross the signed limit without a carry or carry without crossing it. A design that swaps the two middle Y codes, or takes overflow from the wrong carry, fails those vectors. A design that leaks carry_in into the logic path, or leaves the carry flags active in logic mode, fails the full sweep. The sweep covers every operand, select and carry combination against a reference model written from the requirements.

// File: rtl/alu_pkg.sv
// Shared encodings for the selectable ALU.
// Assumes the select word is {mode, code[1:0]} with mode=1 meaning logic.
package alu_pkg;
    typedef enum logic [1:0] {
        Y_ZERO = 2'b00,
        Y_PASS = 2'b01,
        Y_INV  = 2'b10,
        Y_ONES = 2'b11
    } ysel_e;

    typedef enum logic [1:0] {
        L_AND  = 2'b00,
        L_OR   = 2'b01,
        L_XOR  = 2'b10,
        L_NOTA = 2'b11
    } lop_e;
endpackage

// File: rtl/alu_ysel.sv
// Second adder operand steering: zero, B, ~B or all ones per code.
// Assumes code is the shared low select pair.
module alu_ysel
    import alu_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] b_in,
    input  logic [1:0]       code,
    output logic [WIDTH-1:0] y_out
);
    // Pick the adder's second input from the four sources.
    always_comb begin
        unique case (ysel_e'(code))
            Y_ZERO:  y_out = '0;
            Y_PASS:  y_out = b_in;
            Y_INV:   y_out = ~b_in;
            default: y_out = '1;
        endcase
    end
endmodule

// File: rtl/alu_slice.sv
// One bit of the ALU: a full adder on (a, y, cin) and a logic cell on (a, b).
// Assumes y has already been steered by alu_ysel; carry-out is always the adder's.
module alu_slice
    import alu_pkg::*;
(
    input  logic       a,
    input  logic       b,
    input  logic       y,
    input  logic       cin,
    input  logic [2:0] sel,
    output logic       g,
    output logic       cout
);
    logic sum_bit;
    logic log_bit;

    // Full adder for the arithmetic path.
    always_comb begin
        sum_bit = a ^ y ^ cin;
        cout    = (a & y) | (cin & (a ^ y));
    end

    // Bitwise logic function for this bit.
    always_comb begin
        unique case (lop_e'(sel[1:0]))
            L_AND:   log_bit = a & b;
            L_OR:    log_bit = a | b;
            L_XOR:   log_bit = a ^ b;
            default: log_bit = ~a;
        endcase
    end

    // Mode mux between arithmetic and logic.
    always_comb g = sel[2] ? log_bit : sum_bit;
endmodule

// File: rtl/sel_alu.sv
// Selectable ALU top: eight arithmetic and four logic functions from a 3-bit select.
// Purely combinational; assumes WIDTH >= 2 so that the sign carry is distinct.
module sel_alu #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             carry_in,
    input  logic [2:0]       sel,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             overflow
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] y_vec;
    logic [WIDTH:0]   carry;

    alu_ysel #(.WIDTH(WIDTH)) u_ysel (
        .b_in  (opb),
        .code  (sel[1:0]),
        .y_out (y_vec)
    );

    // Chain input carry into the ripple.
    always_comb carry[0] = carry_in;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        alu_slice u_slice (
            .a    (opa[i]),
            .b    (opb[i]),
            .y    (y_vec[i]),
            .cin  (carry[i]),
            .sel  (sel),
            .g    (result[i]),
            .cout (carry[i+1])
        );
    end

    // Flags are only meaningful on the arithmetic side.
    always_comb begin
        carry_out = carry[WIDTH] & ~sel[2];
        overflow  = (carry[WIDTH] ^ carry[MSB]) & ~sel[2];
    end
endmodule

// File: rtl/sel_alu_chk.sv
// Property checker for sel_alu, bound to every instance.
// Combinational block, so the checks are immediate ones on settled values.
module sel_alu_chk #(
    parameter int WIDTH = 4
) (
    input logic [WIDTH-1:0] opa,
    input logic [WIDTH-1:0] opb,
    input logic             carry_in,
    input logic [2:0]       sel,
    input logic [WIDTH-1:0] result,
    input logic             carry_out,
    input logic             overflow
);
    localparam int MSB = WIDTH - 1;
    logic [WIDTH-1:0] y_ref;
    logic [WIDTH:0]   sum_ref;

    // Reference sum from a plain adder.
    always_comb begin
        case (sel[1:0])
            2'b00:   y_ref = '0;
            2'b01:   y_ref = opb;
            2'b10:   y_ref = ~opb;
            default: y_ref = '1;
        endcase
        sum_ref = {1'b0, opa} + {1'b0, y_ref} + {{WIDTH{1'b0}}, carry_in};
    end

    // Immediate checks against the ports.
    always_comb begin
        if (sel[2]) begin
            a_r8_flags_low: assert (!carry_out && !overflow);
        end
        if (!sel[2]) begin
            a_r1_arith_sum: assert ({carry_out, result} == sum_ref);
            a_r6_overflow: assert (overflow ==
                ((opa[MSB] == y_ref[MSB]) && (result[MSB] != opa[MSB])));
        end
        if (sel == 3'b111) begin
            a_r7_not_a: assert (result == ~opa);
        end
        if (sel == 3'b000 && !carry_in) begin
            a_r2_pass: assert (result == opa);
        end
    end
endmodule

bind sel_alu sel_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .opa       (opa),
    .opb       (opb),
    .carry_in  (carry_in),
    .sel       (sel),
    .result    (result),
    .carry_out (carry_out),
    .overflow  (overflow)
);

// File: tb/sim_sel_alu.sv
module sim_sel_alu;
    localparam int W = 4;
    localparam int NV = 18;

    logic         clk = 1'b0;
    logic [W-1:0] opa, opb, result;
    logic         carry_in, carry_out, overflow;
    logic [2:0]   sel;
    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sel_alu #(.WIDTH(W)) u0 (
        .opa(opa), .opb(opb), .carry_in(carry_in), .sel(sel),
        .result(result), .carry_out(carry_out), .overflow(overflow)
    );

    // {sel, cin, a, b, exp_g, exp_c, exp_v}
    localparam logic [17:0] VEC [NV] = '{
        {3'b000, 1'b0, 4'h5, 4'h3, 4'h5, 1'b0, 1'b0},  // R2 pass
        {3'b000, 1'b1, 4'h5, 4'h3, 4'h6, 1'b0, 1'b0},  // R2 inc
        {3'b000, 1'b1, 4'hF, 4'h0, 4'h0, 1'b1, 1'b0},  // R2 inc wrap
        {3'b000, 1'b1, 4'h7, 4'h0, 4'h8, 1'b0, 1'b1},  // R2/R6 inc overflow
        {3'b001, 1'b0, 4'h5, 4'h3, 4'h8, 1'b0, 1'b1},  // R3/R6 ovf no carry
        {3'b001, 1'b1, 4'h9, 4'h8, 4'h2, 1'b1, 1'b1},  // R3 add+1
        {3'b001, 1'b1, 4'hF, 4'hF, 4'hF, 1'b1, 1'b0},  // R6 carry no ovf
        {3'b010, 1'b1, 4'h7, 4'h3, 4'h4, 1'b1, 1'b0},  // R4 sub
        {3'b010, 1'b0, 4'h7, 4'h3, 4'h3, 1'b1, 1'b0},  // R4 a+~b
        {3'b010, 1'b1, 4'h3, 4'h7, 4'hC, 1'b0, 1'b0},  // R4 borrow
        {3'b010, 1'b1, 4'h8, 4'h1, 4'h7, 1'b1, 1'b1},  // R4/R6 sub ovf
        {3'b011, 1'b0, 4'h0, 4'h9, 4'hF, 1'b0, 1'b0},  // R5 dec zero
        {3'b011, 1'b1, 4'h6, 4'h9, 4'h6, 1'b1, 1'b0},  // R5 pass
        {3'b100, 1'b0, 4'hC, 4'hA, 4'h8, 1'b0, 1'b0},  // R7 and
        {3'b101, 1'b1, 4'hC, 4'hA, 4'hE, 1'b0, 1'b0},  // R7/R8 or
        {3'b110, 1'b0, 4'hC, 4'hA, 4'h6, 1'b0, 1'b0},  // R7 xor
        {3'b111, 1'b1, 4'hC, 4'hA, 4'h3, 1'b0, 1'b0},  // R7/R8 not a
        {3'b011, 1'b0, 4'h8, 4'h0, 4'h7, 1'b1, 1'b1}   // R5/R6 dec ovf
    };

    task automatic check(input string req, input logic [W+1:0] got,
                         input logic [W+1:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s sel=%b cin=%b a=%h b=%h {g,c,v} got=%h exp=%h",
                     req, sel, carry_in, opa, opb, got, exp);
        end
    endtask

    task automatic apply(input logic [2:0] s, input logic c,
                         input logic [W-1:0] a, input logic [W-1:0] b);
        sel = s; carry_in = c; opa = a; opb = b;
        #1;
    endtask

    initial begin
        #20000;
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] y, eg;
        logic [W:0]   s;
        logic         ec, ev;
        logic [W-1:0] r0;
        apply(3'b000, 1'b0, '0, '0);
        check("R2 idle", {result, carry_out, overflow}, '0);

        // Table of directed vectors.
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][17:15], VEC[i][14], VEC[i][13:10], VEC[i][9:6]);
            check("R1-table", {result, carry_out, overflow}, VEC[i][5:0]);
        end

        // Full sweep against a requirement model (R1, R6, R7, R8).
        for (int k = 0; k < 8192; k++) begin
            apply(k[12:10], k[9], k[7:4], k[3:0]);
            if (!k[12]) begin
                case (k[11:10])
                    2'b00: y = '0;
                    2'b01: y = k[3:0];
                    2'b10: y = ~k[3:0];
                    default: y = '1;
                endcase
                s  = {1'b0, k[7:4]} + {1'b0, y} + {4'b0, k[9]};
                eg = s[W-1:0];
                ec = s[W];
                ev = (k[7] == y[W-1]) && (s[W-1] != k[7]);
                check("R1/R6 sweep", {result, carry_out, overflow}, {eg, ec, ev});
            end else begin
                case (k[11:10])
                    2'b00: eg = k[7:4] & k[3:0];
                    2'b01: eg = k[7:4] | k[3:0];
                    2'b10: eg = k[7:4] ^ k[3:0];
                    default: eg = ~k[7:4];
                endcase
                check("R7/R8 sweep", {result, carry_out, overflow}, {eg, 2'b00});
            end
        end

        // R8: carry_in toggled in logic mode leaves result unchanged.
        for (int s2 = 4; s2 < 8; s2++) begin
            apply(s2[2:0], 1'b0, 4'h9, 4'h5);
            r0 = result;
            apply(s2[2:0], 1'b1, 4'h9, 4'h5);
            check("R8 cin ignored", {result, carry_out, overflow}, {r0, 2'b00});
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule